// File: doc/BRIEF.md
# Four-Bit ALU Slice with Group Lookahead Outputs

This block is a purely combinational arithmetic logic slice. It takes two 4-bit operands, a 3-bit function code and a carry input. It returns a 4-bit result and a pair of active-low group terms, one for carry generation and one for carry propagation. Several slices can drive an external carry-lookahead unit through those two terms to build wider words. Operands and results use the active-high convention.

The eight function codes give a constant-zero result and a constant-ones result. They give bitwise XOR, OR and AND. They also give three arithmetic forms: addition, and subtraction in either operand order. A subtraction is a true two's-complement difference only when the least significant slice has its carry input held at 1. In the non-arithmetic codes the carry input has no effect. In those codes the group terms take the value that lets a lookahead chain pass its incoming carry straight through.

Top module: `alu_slice4`

## Requirements
- R1: Function code 3'b000 (clear) drives the result to 4'h0.
- R2: Code 3'b001 gives result = (B + ~A + carry_in) mod 16, so with carry_in=1 the result is B minus A.
- R3: Code 3'b010 gives result = (A + ~B + carry_in) mod 16, so with carry_in=1 the result is A minus B.
- R4: Code 3'b011 gives result = (A + B + carry_in) mod 16.
- R5: Code 3'b100 gives result = A XOR B.
- R6: Code 3'b101 gives result = A OR B.
- R7: Code 3'b110 gives result = A AND B.
- R8: Code 3'b111 (preset) drives the result to 4'hF.
- R9: In codes 3'b000 and 3'b100 through 3'b111, carry_in has no effect on any output.
- R10: In the three arithmetic codes, grp_prop_n is 0 exactly when every bit of (X OR Y) is 1. X and Y are the operands after the mode's inversion: X=~A, Y=B for code 1; X=A, Y=~B for code 2; X=A, Y=B for code 3.
- R11: In the arithmetic codes, grp_gen_n is 0 exactly when X + Y with no carry in overflows 4 bits.
- R12: In the non-arithmetic codes, grp_gen_n is 1 and grp_prop_n is 0.
- R13: In the arithmetic codes, the carry out implied by the group terms, (~grp_gen_n) | (~grp_prop_n & carry_in), together with the result, equals the 5-bit value X + Y + carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| func_sel | input | 3 | Function code; bit 0, bit 1 and bit 2 select as listed in the requirements |
| carry_in | input | 1 | Carry into the least significant bit |
| result | output | 4 | Function result |
| grp_gen_n | output | 1 | Group carry generate, active low |
| grp_prop_n | output | 1 | Group carry propagate, active low |

## Verification
The assertions check, on every evaluation, that the constant codes give all zeros or all ones. They check that the group terms are parked in the non-arithmetic codes, and that AND never sets a bit OR leaves clear. They also check that the adder's sum and final carry agree with a plain 5-bit addition and with its own group terms. The bench alone can show that each code maps to the right operation and the right operand order. It also shows that the carry input is truly ignored outside arithmetic, by comparing outputs with carry_in at 0 and at 1. It also checks the group terms seen at the ports against an independent model over every operand pair.

// File: rtl/alu_slice4_pkg.sv
package alu_slice4_pkg;

  typedef enum logic [2:0] {
    FN_CLEAR   = 3'd0,
    FN_B_SUB_A = 3'd1,
    FN_A_SUB_B = 3'd2,
    FN_ADD     = 3'd3,
    FN_XOR     = 3'd4,
    FN_OR      = 3'd5,
    FN_AND     = 3'd6,
    FN_SET     = 3'd7
  } func_e;

  function automatic logic is_arith(func_e fn);
    return (fn == FN_B_SUB_A) || (fn == FN_A_SUB_B) || (fn == FN_ADD);
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond
  import alu_slice4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  func_e            fn_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic             arith_o
);

  // Inversion of one operand turns an adder into a subtractor once the
  // least significant carry is forced high.
  always_comb begin
    x_o = a_i;
    y_o = b_i;
    unique case (fn_i)
      FN_B_SUB_A: x_o = ~a_i;
      FN_A_SUB_B: y_o = ~b_i;
      default: ;
    endcase
  end

  assign arith_o = is_arith(fn_i);

  always_comb begin
    if (fn_i == FN_B_SUB_A) begin
      p_invert_a_r2: assert ((x_o ^ a_i) == '1 && y_o == b_i);
    end
    if (fn_i == FN_A_SUB_B) begin
      p_invert_b_r3: assert ((y_o ^ b_i) == '1 && x_o == a_i);
    end
  end

endmodule

// File: rtl/alu_cla_core.sv
module alu_cla_core #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);

  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] bit_gen;
  logic [WIDTH-1:0] bit_prop;
  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] gen_chain;
  logic [WIDTH-1:0] prop_chain;
  logic [WIDTH:0]   carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_gen[i]  = x_i[i] & y_i[i];
    assign bit_prop[i] = x_i[i] | y_i[i];
    assign half_sum[i] = x_i[i] ^ y_i[i];
    assign carry[i+1]  = bit_gen[i] | (bit_prop[i] & carry[i]);
    assign sum_o[i]    = half_sum[i] ^ carry[i];
    if (i == 0) begin : g_first
      assign gen_chain[i]  = bit_gen[i];
      assign prop_chain[i] = bit_prop[i];
    end else begin : g_rest
      assign gen_chain[i]  = bit_gen[i] | (bit_prop[i] & gen_chain[i-1]);
      assign prop_chain[i] = bit_prop[i] & prop_chain[i-1];
    end
  end

  assign grp_gen_o  = gen_chain[WIDTH-1];
  assign grp_prop_o = prop_chain[WIDTH-1];

  always_comb begin
    p_sum_matches_r13: assert ({carry[WIDTH], sum_o} ==
                               EXT'(x_i) + EXT'(y_i) + EXT'(cin_i));
    p_group_carry_r11: assert (carry[WIDTH] == (grp_gen_o | (grp_prop_o & cin_i)));
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  func_e            fn_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] and_res;
  logic [WIDTH-1:0] or_res;
  logic [WIDTH-1:0] xor_res;

  assign and_res = a_i & b_i;
  assign or_res  = a_i | b_i;
  assign xor_res = a_i ^ b_i;

  always_comb begin
    unique case (fn_i)
      FN_XOR:  res_o = xor_res;
      FN_OR:   res_o = or_res;
      FN_AND:  res_o = and_res;
      FN_SET:  res_o = '1;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    p_and_within_or_r7: assert ((and_res & ~or_res) == '0);
    p_xor_split_r5: assert ((xor_res | and_res) == or_res);
  end

endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
  import alu_slice4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       func_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             grp_gen_n,
  output logic             grp_prop_n
);

  func_e            fn;
  logic [WIDTH-1:0] x_op;
  logic [WIDTH-1:0] y_op;
  logic             arith;
  logic [WIDTH-1:0] sum;
  logic             grp_gen;
  logic             grp_prop;
  logic [WIDTH-1:0] logic_res;

  assign fn = func_e'(func_sel);

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .a_i     (op_a),
    .b_i     (op_b),
    .fn_i    (fn),
    .x_o     (x_op),
    .y_o     (y_op),
    .arith_o (arith)
  );

  alu_cla_core #(.WIDTH(WIDTH)) u_core (
    .x_i        (x_op),
    .y_i        (y_op),
    .cin_i      (carry_in),
    .sum_o      (sum),
    .grp_gen_o  (grp_gen),
    .grp_prop_o (grp_prop)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (op_a),
    .b_i   (op_b),
    .fn_i  (fn),
    .res_o (logic_res)
  );

  // Outside arithmetic the group terms park at "propagate, no generate"
  // so a lookahead unit forwards its incoming carry unchanged.
  assign result     = arith ? sum : logic_res;
  assign grp_gen_n  = arith ? ~grp_gen  : 1'b1;
  assign grp_prop_n = arith ? ~grp_prop : 1'b0;

  always_comb begin
    if (fn == FN_CLEAR) begin
      p_clear_zero_r1: assert (result == '0);
    end
    if (fn == FN_SET) begin
      p_preset_ones_r8: assert (result == '1);
    end
    if (!arith) begin
      p_parked_group_r12: assert (grp_gen_n && !grp_prop_n);
    end
  end

endmodule

// File: tb/alu_slice4_bench.sv
module alu_slice4_bench;

  logic       clk = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [2:0] func_sel = '0;
  logic       carry_in = 1'b0;
  logic [3:0] result;
  logic       grp_gen_n;
  logic       grp_prop_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_slice4 u_alu_slice4 (
    .op_a       (op_a),
    .op_b       (op_b),
    .func_sel   (func_sel),
    .carry_in   (carry_in),
    .result     (result),
    .grp_gen_n  (grp_gen_n),
    .grp_prop_n (grp_prop_n)
  );

  // {sel, a, b, cin, expected result, expected gen_n, expected prop_n}
  localparam int NVEC = 14;
  localparam logic [17:0] VEC [NVEC] = '{
    {3'd0, 4'h5, 4'h3, 1'b1, 4'h0, 1'b1, 1'b0},  // R1
    {3'd1, 4'h3, 4'h9, 1'b1, 4'h6, 1'b0, 1'b1},  // R2
    {3'd1, 4'h9, 4'h3, 1'b1, 4'hA, 1'b1, 1'b1},  // R2
    {3'd2, 4'h7, 4'h2, 1'b1, 4'h5, 1'b0, 1'b0},  // R3
    {3'd2, 4'h4, 4'h4, 1'b0, 4'hF, 1'b1, 1'b0},  // R3
    {3'd3, 4'hF, 4'h1, 1'b0, 4'h0, 1'b0, 1'b0},  // R4
    {3'd3, 4'h6, 4'h5, 1'b1, 4'hC, 1'b1, 1'b1},  // R4
    {3'd4, 4'hA, 4'h6, 1'b1, 4'hC, 1'b1, 1'b0},  // R5
    {3'd5, 4'hA, 4'h5, 1'b0, 4'hF, 1'b1, 1'b0},  // R6
    {3'd6, 4'hC, 4'hA, 1'b1, 4'h8, 1'b1, 1'b0},  // R7
    {3'd7, 4'h0, 4'h0, 1'b0, 4'hF, 1'b1, 1'b0},  // R8
    {3'd0, 4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 1'b0},  // R1
    {3'd3, 4'h0, 4'h0, 1'b1, 4'h1, 1'b1, 1'b1},  // R4
    {3'd1, 4'h0, 4'h0, 1'b1, 4'h0, 1'b1, 1'b0}   // R2
  };

  task automatic apply(input logic [2:0] s, input logic [3:0] a,
                       input logic [3:0] b, input logic c);
    @(negedge clk);
    func_sel = s; op_a = a; op_b = b; carry_in = c;
    #2;
  endtask

  task automatic check(input string req, input logic [3:0] ef,
                       input logic eg, input logic ep);
    total++;
    if (result !== ef || grp_gen_n !== eg || grp_prop_n !== ep) begin
      bad++;
      $display("FAIL %s sel=%0d a=%h b=%h cin=%0b: got f=%h g_n=%0b p_n=%0b exp f=%h g_n=%0b p_n=%0b",
               req, func_sel, op_a, op_b, carry_in, result, grp_gen_n, grp_prop_n, ef, eg, ep);
    end
  endtask

  function automatic logic [5:0] model(input logic [2:0] s, input logic [3:0] a,
                                       input logic [3:0] b, input logic c);
    logic [3:0] x, y, f;
    int sum5, raw;
    logic g_n, p_n;
    x = (s == 3'd1) ? ~a : a;
    y = (s == 3'd2) ? ~b : b;
    sum5 = int'(x) + int'(y) + int'(c);
    raw  = int'(x) + int'(y);
    g_n = 1'b1; p_n = 1'b0;
    case (s)
      3'd0: f = 4'h0;
      3'd4: f = a ^ b;
      3'd5: f = a | b;
      3'd6: f = a & b;
      3'd7: f = 4'hF;
      default: begin
        f   = 4'(sum5 % 16);
        g_n = !(raw >= 16);
        p_n = !((x | y) == 4'hF);
      end
    endcase
    return {f, g_n, p_n};
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2/R10/R11/R13";
      3'd2: return "R3/R10/R11/R13";
      3'd3: return "R4/R10/R11/R13";
      3'd4: return "R5/R12";
      3'd5: return "R6/R12";
      3'd6: return "R7/R12";
      default: return "R8/R12";
    endcase
  endfunction

  initial begin
    // Power-up state with all inputs low: clear code, parked group terms (R1, R12)
    #2;
    check("R1 initial", 4'h0, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [17:0] v;
      v = VEC[i];
      apply(v[17:15], v[14:11], v[10:7], v[6]);
      check(req_of(v[17:15]), v[5:2], v[1], v[0]);
    end

    // Exhaustive sweep against the model
    for (int s = 0; s < 8; s++) begin
      for (int ab = 0; ab < 256; ab++) begin
        for (int c = 0; c < 2; c++) begin
          logic [5:0] e;
          e = model(3'(s), 4'(ab >> 4), 4'(ab), 1'(c));
          apply(3'(s), 4'(ab >> 4), 4'(ab), 1'(c));
          check(req_of(3'(s)), e[5:2], e[1], e[0]);
        end
      end
    end

    // R9: carry_in toggled in non-arithmetic codes leaves outputs unchanged
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s >= 4) begin
        logic [3:0] f0;
        logic g0, p0;
        apply(3'(s), 4'h9, 4'h6, 1'b0);
        f0 = result; g0 = grp_gen_n; p0 = grp_prop_n;
        apply(3'(s), 4'h9, 4'h6, 1'b1);
        check("R9 carry ignored", f0, g0, p0);
      end
    end

    // R13: implied carry out from group terms, at the all-propagate corner
    apply(3'd3, 4'hA, 4'h5, 1'b1);
    total++;
    if ({(~grp_gen_n) | (~grp_prop_n & carry_in), result} !== 5'h10) begin
      bad++;
      $display("FAIL R13 got %h exp %h", {(~grp_gen_n) | (~grp_prop_n & carry_in), result}, 5'h10);
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule